// File: doc/BRIEF.md
# Stack Pointer Sync-Uop Inserter

This block sits in a processor front end beside a stack engine that absorbs implicit stack-pointer adjustments from push, pop, call and return style instructions. It keeps a running signed offset of the adjustments that have not yet been written into the architectural stack pointer. For each instruction it decides whether a synchronization micro-op has to be placed into the micro-op queue ahead of that instruction's own micro-ops, so that the real stack pointer catches up with the offset.

The decision runs only on the first micro-op of an instruction and follows a fixed order. An explicit read of the stack pointer while the offset is nonzero forces a sync and clears the offset first. The instruction's implicit delta is then added, and a sum above 192 forces a sync and clears the offset. An explicit write of the stack pointer clears the offset last, without a sync of its own. The insert strobe is combinational, so the queue can push the sync micro-op in the same cycle, ahead of the instruction. The sync micro-op itself reads and writes the stack pointer with latency 1 on any ALU port. It carries a source tag that marks it as coming from the stack engine.

Top module: `stackSyncInserter`

## Requirements
- R1: After reset the offset output is 0 and the sync strobe is low.
- R2: When `instrValid` or `firstUop` is low, the sync strobe stays low and the offset holds its value at the next clock edge.
- R3: On a first micro-op with `spExplicitRead` high and a nonzero offset, the sync strobe is high in the same cycle and the offset is cleared before the delta is added, so the next offset equals the delta (unless R6 or R7 applies).
- R4: On a first micro-op with `spExplicitRead` high and a zero offset, the read alone raises no sync.
- R5: On a first micro-op, the signed `spDelta` is added to the offset, and the sum is the next offset when no clear applies.
- R6: When the offset after the R3 step plus the delta is greater than 192 (signed), the sync strobe is high and the next offset is 0; a sum of exactly 192 raises no sync.
- R7: On a first micro-op with `spExplicitWrite` high, the next offset is 0, and the write alone raises no sync.
- R8: At most one sync is requested per instruction: the strobe is a single bit, high once even when both the R3 and the R6 conditions hold.
- R9: `syncSrcTag` is 2'b11 (stack-engine source) whenever the sync strobe is high and 2'b00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Micro-op presented this cycle |
| firstUop | input | 1 | Micro-op is the first of its instruction |
| spDelta | input | DELTA_W | Signed implicit stack-pointer change of the instruction |
| spExplicitRead | input | 1 | Instruction reads the stack pointer as a register or address operand (implicit stack operands excluded) |
| spExplicitWrite | input | 1 | Instruction writes the stack pointer explicitly |
| syncValid | output | 1 | Insert one sync micro-op ahead of this instruction |
| syncSrcTag | output | 2 | Source code of the inserted micro-op |
| spOffset | output | OFF_W | Current running offset |

## Verification
On every cycle the assertions check that a sync strobe only appears on a valid first micro-op, that the offset never rests above 192, that an explicit write leaves a zero offset, that an idle cycle leaves the offset untouched, and that the source tag tracks the strobe. The ordering questions need the bench's sweep: whether the read-triggered clear happens before the delta is added, whether exactly 192 stays without a sync while 193 syncs, and whether a zero offset lets an explicit read pass without a sync. The sweep covers every delta value against every combination of the four control inputs, starting from the offsets that the sequence itself builds up, and compares with an arithmetic model.

// File: rtl/stackSyncPkg.sv
package stackSyncPkg;
  localparam int OFF_W_DEF   = 16;
  localparam int DELTA_W_DEF = 8;
  localparam int THRESH_DEF  = 192;

  localparam logic [1:0] SRC_NONE  = 2'b00;
  localparam logic [1:0] SRC_STACK = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic accumulate;   // valid first micro-op: add delta
    logic clearBefore;  // explicit read with pending offset
    logic clearAfter;   // explicit write of the stack pointer
  } syncCtrlT;
endpackage

// File: rtl/stackOffsetPath.sv
module stackOffsetPath
  import stackSyncPkg::*;
#(
  parameter int OFF_W   = OFF_W_DEF,
  parameter int DELTA_W = DELTA_W_DEF,
  parameter int THRESH  = THRESH_DEF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  syncCtrlT                  ctrl,
  input  logic signed [DELTA_W-1:0] delta,
  output logic                      offsetNonZero,
  output logic                      overThresh,
  output logic signed [OFF_W-1:0]   offset
);
  localparam int SUM_W = OFF_W + 1;
  localparam logic signed [SUM_W-1:0] THRESH_S = SUM_W'(THRESH);

  logic signed [OFF_W-1:0] offsetQ;
  logic signed [OFF_W-1:0] baseVal;
  logic signed [SUM_W-1:0] sumVal;
  logic signed [OFF_W-1:0] offsetNext;

  always_comb begin
    baseVal    = ctrl.clearBefore ? '0 : offsetQ;
    sumVal     = {baseVal[OFF_W-1], baseVal}
               + {{(SUM_W-DELTA_W){delta[DELTA_W-1]}}, delta};
    overThresh = ctrl.accumulate && (sumVal > THRESH_S);
    offsetNext = offsetQ;
    if (ctrl.accumulate) begin
      if (overThresh || ctrl.clearAfter) offsetNext = '0;
      else                               offsetNext = sumVal[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) offsetQ <= '0;
    else       offsetQ <= offsetNext;
  end

  assign offset        = offsetQ;
  assign offsetNonZero = (offsetQ != '0);

  // R6
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    offsetQ <= OFF_W'(THRESH));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.accumulate |=> $stable(offsetQ));
endmodule

// File: rtl/stackSyncCtrl.sv
module stackSyncCtrl
  import stackSyncPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     instrValid,
  input  logic     firstUop,
  input  logic     spExplicitRead,
  input  logic     spExplicitWrite,
  input  logic     offsetNonZero,
  input  logic     overThresh,
  output syncCtrlT ctrl,
  output logic     syncValid
);
  always_comb begin
    ctrl.accumulate  = instrValid && firstUop;
    ctrl.clearBefore = ctrl.accumulate && spExplicitRead && offsetNonZero;
    ctrl.clearAfter  = ctrl.accumulate && spExplicitWrite;
  end

  // one strobe per instruction, whichever cause fires
  assign syncValid = ctrl.clearBefore || overThresh;

  // R2
  sync_only_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncValid |-> (instrValid && firstUop));

  // R3
  read_pending_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && firstUop && spExplicitRead && offsetNonZero) |-> syncValid);

  // R7
  write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && firstUop && spExplicitWrite) |=> !offsetNonZero);
endmodule

// File: rtl/stackSyncInserter.sv
module stackSyncInserter
  import stackSyncPkg::*;
#(
  parameter int OFF_W   = OFF_W_DEF,
  parameter int DELTA_W = DELTA_W_DEF,
  parameter int THRESH  = THRESH_DEF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instrValid,
  input  logic                      firstUop,
  input  logic signed [DELTA_W-1:0] spDelta,
  input  logic                      spExplicitRead,
  input  logic                      spExplicitWrite,
  output logic                      syncValid,
  output logic [1:0]                syncSrcTag,
  output logic signed [OFF_W-1:0]   spOffset
);
  syncCtrlT ctrl;
  logic     offsetNonZero;
  logic     overThresh;

  stackSyncCtrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .instrValid     (instrValid),
    .firstUop       (firstUop),
    .spExplicitRead (spExplicitRead),
    .spExplicitWrite(spExplicitWrite),
    .offsetNonZero  (offsetNonZero),
    .overThresh     (overThresh),
    .ctrl           (ctrl),
    .syncValid      (syncValid)
  );

  stackOffsetPath #(
    .OFF_W  (OFF_W),
    .DELTA_W(DELTA_W),
    .THRESH (THRESH)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .delta        (spDelta),
    .offsetNonZero(offsetNonZero),
    .overThresh   (overThresh),
    .offset       (spOffset)
  );

  assign syncSrcTag = syncValid ? SRC_STACK : SRC_NONE;

  // R9
  tag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncValid == (syncSrcTag == SRC_STACK)) && (syncValid || syncSrcTag == SRC_NONE));
endmodule

// File: tb/test_stackSyncInserter.sv
module test_stackSyncInserter;
  localparam int OFF_W = 16;
  localparam int DELTA_W = 8;

  logic clk = 0;
  logic rstN = 0;
  logic instrValid = 0, firstUop = 0, spExplicitRead = 0, spExplicitWrite = 0;
  logic signed [DELTA_W-1:0] spDelta = '0;
  logic syncValid;
  logic [1:0] syncSrcTag;
  logic signed [OFF_W-1:0] spOffset;

  int checks = 0, errors = 0;
  int modelOff = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stackSyncInserter i_stackSyncInserter (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .firstUop(firstUop),
    .spDelta(spDelta), .spExplicitRead(spExplicitRead), .spExplicitWrite(spExplicitWrite),
    .syncValid(syncValid), .syncSrcTag(syncSrcTag), .spOffset(spOffset)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply one micro-op, compare strobe, tag and next offset with the model
  task automatic stepOp(bit v, bit f, bit rd, bit wr, int d);
    int o, sum, expOff;
    bit s;
    string tag;
    @(negedge clk);
    instrValid = v; firstUop = f; spExplicitRead = rd; spExplicitWrite = wr;
    spDelta = DELTA_W'(d);
    o = modelOff; s = 0; expOff = modelOff; sum = 0;
    tag = "R2";
    if (v && f) begin
      if (rd && o != 0) begin s = 1; o = 0; end
      sum = o + d;
      if (sum > 192) begin s = 1; expOff = 0; end
      else expOff = int'($signed(OFF_W'(sum)));
      if (wr) expOff = 0;
      if (rd && modelOff != 0 && sum > 192) tag = "R8";
      else if (rd && modelOff != 0) tag = "R3";
      else if (sum > 192) tag = "R6";
      else if (wr) tag = "R7";
      else if (rd) tag = "R4";
      else tag = "R5";
    end
    #1;
    check(tag, int'(syncValid), int'(s));
    check("R9", int'(syncSrcTag), s ? 3 : 0);
    @(posedge clk); #1;
    check(tag, int'(spOffset), expOff);
    modelOff = expOff;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(spOffset), 0);
    check("R1", int'(syncValid), 0);
    @(negedge clk); rstN = 1;

    // boundary: exactly 192 stays, one more syncs
    stepOp(1, 1, 0, 0, 64);
    stepOp(1, 1, 0, 0, 64);
    stepOp(1, 1, 0, 0, 64);   // 192, no sync (R6)
    stepOp(1, 0, 1, 1, 100);  // later micro-op ignored (R2)
    stepOp(0, 1, 1, 1, 100);  // invalid ignored (R2)
    stepOp(1, 1, 0, 0, 1);    // 193 -> sync, cleared (R6)
    stepOp(1, 1, 1, 0, 10);   // zero offset read: no sync (R4)
    stepOp(1, 1, 1, 0, 5);    // pending read: sync, offset = 5 (R3)
    stepOp(1, 1, 0, 1, -8);   // write clears, no sync (R7)
    stepOp(1, 1, 0, 0, 127);
    stepOp(1, 1, 1, 0, 127);  // read cleared first: 127, no overflow (R3)
    stepOp(1, 1, 0, 0, 66);   // 193 (R6)

    // sweep of every delta against every control combination
    for (int d = -128; d < 128; d++)
      for (int m = 0; m < 16; m++)
        stepOp(m[3], m[2], m[1], m[0], d);

    // reset mid-run returns to zero
    stepOp(1, 1, 0, 0, 50);
    @(negedge clk); rstN = 0;
    @(posedge clk); #1;
    check("R1", int'(spOffset), 0);
    modelOff = 0;
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule